// File: doc/BRIEF.md
# Watchdog Reset and Power-Down Pin Controller

This block serves one package pin that does one of two jobs, chosen by a mode strap captured at power-up. In the reset role, a watchdog counter runs on the reference clock. If software stops kicking it, the block pulls the pin low through an open-drain driver for a fixed number of reference cycles. That low level acts as a system reset pulse. In the power-down role, the pin becomes an active-low input. A low level on it, after a two-flop synchroniser, raises a stop-all-clocks request toward the output gating logic. That request also stops the memory fanout clocks.

The watchdog period and the pulse length are both parameters in reference cycles. At a 14.318 MHz reference, the default pulse of 57,272 cycles lasts about 4 ms. A kick reloads the counter and arms the watchdog. An enable input pauses counting without losing progress. A timeout produces exactly one pulse. After the pulse the watchdog stays disarmed until the next kick, so a dead system is not reset over and over.

Top module: `wdt_pin_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `pin_pull_low` and `clocks_stop` are 0. The count starts at zero with the watchdog armed.
- R2: In the reset role (`strap_reset_role`=1), with the watchdog armed, `pin_pull_low` rises right after the TIMEOUT_CYC-th clock edge that samples `wd_enable`=1 with no kick since the last kick or reset.
- R3: Once high, `pin_pull_low` stays high for exactly PULSE_CYC clock cycles and then returns to 0.
- R4: After a pulse, with no kick, no further pulse occurs however long `wd_enable` stays 1. A kick re-arms the watchdog for a full period.
- R5: A kick sampled on an edge clears the count. The next timeout comes TIMEOUT_CYC enabled edges after that kick. A kick on the edge that would have timed out prevents the timeout.
- R6: Edges that sample `wd_enable`=0 do not advance the count and do not clear it.
- R7: In the power-down role (`strap_reset_role`=0), `pin_pull_low` stays 0 whatever `wd_enable` and `wd_kick` do.
- R8: In the power-down role, `clocks_stop` after clock edge N equals the inverse of `pin_in` as sampled on edge N-1, which is two register stages. The synchroniser starts out at the released (high) level.
- R9: In the reset role, `clocks_stop` stays 0 whatever `pin_in` does.
- R10: A kick during a pulse does not shorten the pulse. The counting for the re-armed watchdog starts only after the pin is released, so the next rise comes TIMEOUT_CYC enabled edges after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wd_enable | input | 1 | 1 lets the watchdog count on this edge |
| wd_kick | input | 1 | 1 clears the watchdog count and arms the watchdog |
| strap_reset_role | input | 1 | Mode strap latched at power-up: 1 selects the reset-output role, 0 selects the power-down-input role |
| pin_in | input | 1 | Sampled level of the shared pin |
| pin_pull_low | output | 1 | Open-drain enable: 1 pulls the pin low, 0 releases it |
| clocks_stop | output | 1 | 1 asks the gating logic to stop all clock outputs |

## Verification
The hardest case to reach is a kick that arrives during a pulse, or exactly on the edge where the count would expire. Reaching it needs an exact cycle position measured from an earlier kick or from a pin release. The bench uses a small period and pulse length. It sweeps the kick offset over every position inside one period, including the last. It replays the enable input with several periodic gap patterns and one long gap. For each case it computes the expected rise cycle by counting enabled edges.

// File: rtl/wdt_pin_pkg.sv
// Package: shared types for the watchdog/power-down pin controller.
// Assumes: the strap encoding is fixed by the board pull-up (1 = reset role).
package wdt_pin_pkg;

    // Role of the shared pin, decoded from the power-up strap.
    typedef enum logic {
        ROLE_PWRDN = 1'b0,
        ROLE_RESET = 1'b1
    } pin_role_e;

    // Minimum synchroniser depth used when guarding parameters.
    localparam int unsigned SYNC_MIN = 1;

endpackage

// File: rtl/wdt_period_ctr.sv
// Module: watchdog period counter.
// Counts edges on which run is high. Raises expire for one cycle when the
// TIMEOUT_CYC-th counted edge comes and the counter is armed. After it
// expires, it disarms itself and holds until the next kick.
// Assumes: kick takes priority over expiry on the same edge.
module wdt_period_ctr #(
    parameter int unsigned TIMEOUT_CYC = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] count_q;
    logic          armed_q;

    // Timeout condition on this edge.
    assign expire = armed_q & run & ~kick & (count_q == LAST);

    // Count enabled edges; kick reloads and arms, expiry reloads and disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            armed_q <= 1'b1;
        end else if (kick) begin
            count_q <= '0;
            armed_q <= 1'b1;
        end else if (expire) begin
            count_q <= '0;
            armed_q <= 1'b0;
        end else if (armed_q && run) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_pulse_gen.sv
// Module: fixed-length pulse generator.
// A start strobe makes active high for exactly PULSE_CYC cycles.
// Assumes: start is never raised while active is high (the caller gates it).
module wdt_pulse_gen #(
    parameter int unsigned PULSE_CYC = 57_272
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int unsigned PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] LEN = PW'(PULSE_CYC);

    logic [PW-1:0] left_q;

    // Pulse is on while cycles remain.
    assign active = (left_q != '0);

    // Load the length on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LEN;
        end else if (active) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdt_pd_sync.sv
// Module: level synchroniser for the power-down pin sample.
// Passes din through STAGES flops, all of which reset to the released
// (high) level.
// Assumes: STAGES >= 1; the depth picks a single-flop or shift-chain variant.
module wdt_pd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= din;
            end
        end else begin : g_chain
            // Shift the sample along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/wdt_pin_ctrl.sv
// Module: watchdog reset / power-down pin controller (top).
// In the reset role, a watchdog timeout drives an open-drain low pulse of
// PULSE_CYC cycles onto the pin. In the power-down role, a synchronised
// low level on the pin raises clocks_stop.
// Assumes: strap_reset_role is static after reset; pin_in is asynchronous.
module wdt_pin_ctrl
    import wdt_pin_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1_000_000,
    parameter int unsigned PULSE_CYC   = 57_272,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic wd_enable,
    input  logic wd_kick,
    input  logic strap_reset_role,
    input  logic pin_in,
    output logic pin_pull_low,
    output logic clocks_stop
);
    localparam int unsigned SYNC_N = (SYNC_STAGES < SYNC_MIN) ? SYNC_MIN : SYNC_STAGES;

    pin_role_e role;
    logic      pulse_on;
    logic      run;
    logic      expire;
    logic      pd_level;

    // Decode the strap into the pin role.
    assign role = pin_role_e'(strap_reset_role);

    // Count only in the reset role, when enabled, and outside a pulse.
    assign run = wd_enable & (role == ROLE_RESET) & ~pulse_on;

    wdt_period_ctr #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_period (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .kick   (wd_kick),
        .run    (run),
        .expire (expire)
    );

    wdt_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .start  (expire),
        .active (pulse_on)
    );

    wdt_pd_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pd_level)
    );

    // Open-drain enable follows the pulse.
    assign pin_pull_low = pulse_on;

    // Stop request only when the pin is an input and is held low.
    assign clocks_stop = (role == ROLE_PWRDN) & ~pd_level;
endmodule

// File: rtl/wdt_pin_chk.sv
// Module: assertion checker for wdt_pin_ctrl, attached by bind.
// Keeps small port-level models (enabled-edge count, arm state, pulse length)
// and checks the pin behaviour against them.
// Assumes: the strap only changes while reset is asserted.
module wdt_pin_chk #(
    parameter int unsigned TIMEOUT_CYC = 1_000_000,
    parameter int unsigned PULSE_CYC   = 57_272
) (
    input logic clk,
    input logic rst_n,
    input logic kick,
    input logic enable,
    input logic strap,
    input logic pin_in,
    input logic pin_pull_low,
    input logic clocks_stop
);
    logic [31:0] high_len;
    logic [31:0] run_seen;
    logic        armed_m;
    logic        prev_high;
    logic [1:0]  since_rst;

    // Port-level models of pulse length, enabled edges, arm state and reset age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_len  <= '0;
            run_seen  <= '0;
            armed_m   <= 1'b1;
            prev_high <= 1'b0;
            since_rst <= '0;
        end else begin
            prev_high <= pin_pull_low;
            if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
            if (pin_pull_low) high_len <= high_len + 1'b1;
            else              high_len <= '0;
            if (kick || pin_pull_low)                  run_seen <= '0;
            else if (enable && strap && run_seen != '1) run_seen <= run_seen + 1'b1;
            if (kick)                            armed_m <= 1'b1;
            else if (pin_pull_low && !prev_high) armed_m <= 1'b0;
        end
    end

    // R2: a pulse begins only after a full enabled period in the reset role.
    p_rise_after_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_pull_low) |-> (strap && run_seen == TIMEOUT_CYC));

    // R3: every pulse lasts exactly PULSE_CYC cycles.
    p_pulse_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_pull_low) |-> (high_len == PULSE_CYC));

    // R4: a pulse needs the watchdog to be armed.
    p_one_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_pull_low) |-> armed_m);

    // R7: never pull the pin in the power-down role.
    p_quiet_in_pd_role_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !strap |-> !pin_pull_low);

    // R8: the stop request follows the pin two stages later.
    p_stop_follows_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && !strap) |-> (clocks_stop == !$past(pin_in, 2)));
endmodule

bind wdt_pin_ctrl wdt_pin_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .PULSE_CYC   (PULSE_CYC)
) u_chk (
    .clk          (clk_ref),
    .rst_n        (rst_n),
    .kick         (wd_kick),
    .enable       (wd_enable),
    .strap        (strap_reset_role),
    .pin_in       (pin_in),
    .pin_pull_low (pin_pull_low),
    .clocks_stop  (clocks_stop)
);

// File: tb/sim_wdt_pin_ctrl.sv
// Bench: sweeps kick offsets, enable gap patterns and pin patterns on a
// small configuration; expected cycles are computed by counting edges.
module sim_wdt_pin_ctrl;
    localparam int  T = 12;
    localparam int  P = 5;
    localparam time CLK_PERIOD = 10;
    localparam int  MAX_CYC = 200000;

    logic clk = 1'b0;
    logic rst_n, en, kick, strap, pin_in;
    logic pull, stop;
    int   checks = 0;
    int   fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_pin_ctrl #(.TIMEOUT_CYC(T), .PULSE_CYC(P), .SYNC_STAGES(2)) u0 (
        .clk_ref (clk), .rst_n (rst_n), .wd_enable (en), .wd_kick (kick),
        .strap_reset_role (strap), .pin_in (pin_in),
        .pin_pull_low (pull), .clocks_stop (stop)
    );

    // Advance one edge, then settle away from it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Compare one bit and record the result.
    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Apply reset with a given strap and check the quiet state.
    task automatic do_reset(input logic s);
        rst_n = 1'b0; strap = s; en = 1'b0; kick = 1'b0; pin_in = 1'b1;
        repeat (3) step();
        chk(pull, 1'b0, "R1 pull in reset");
        chk(stop, 1'b0, "R1 stop in reset");
        rst_n = 1'b1;
    endtask

    // Single kick edge.
    task automatic pulse_kick();
        kick = 1'b1; step(); kick = 1'b0;
        chk(pull, 1'b0, "R5 no pulse on kick edge");
    endtask

    // Expect a rise exactly n edges from now.
    task automatic expect_rise(input int n, input string tag);
        for (int i = 1; i <= n; i++) begin
            step();
            chk(pull, logic'(i == n), tag);
        end
    endtask

    // Rise already seen: expect the rest of the pulse, then release.
    task automatic finish_pulse();
        for (int i = 2; i <= P; i++) begin
            step();
            chk(pull, 1'b1, "R3 pulse held");
        end
        step();
        chk(pull, 1'b0, "R3 pulse released");
    endtask

    task automatic run_all();
        // Reset role: free-running timeout from reset.
        do_reset(1'b1);
        en = 1'b1;
        expect_rise(T, "R2 first timeout");
        finish_pulse();
        // One-shot: no second pulse without a kick.
        for (int i = 0; i < 3 * T; i++) begin
            step();
            chk(pull, 1'b0, "R4 no repeat");
        end
        pulse_kick();
        expect_rise(T, "R4 rearm by kick");
        finish_pulse();

        // Kick offset sweep, including a kick on the would-be timeout edge.
        for (int k = 1; k < T; k++) begin
            pulse_kick();
            for (int i = 0; i < k; i++) begin
                step();
                chk(pull, 1'b0, "R5 before second kick");
            end
            pulse_kick();
            expect_rise(T, "R5 period from kick");
            finish_pulse();
        end

        // Enable gap patterns.
        for (int m = 2; m <= 4; m++) begin
            int ens = 0;
            int i = 0;
            pulse_kick();
            while (ens < T) begin
                en = logic'((i % m) != 0);
                step();
                if (en) ens++;
                chk(pull, logic'(ens == T), "R6 gated count");
                i++;
            end
            en = 1'b1;
            finish_pulse();
        end
        // Long disabled gap keeps progress.
        pulse_kick();
        for (int i = 0; i < T - 2; i++) step();
        en = 1'b0;
        for (int i = 0; i < 3 * T; i++) begin
            step();
            chk(pull, 1'b0, "R6 held while disabled");
        end
        en = 1'b1;
        expect_rise(2, "R6 resume after gap");
        finish_pulse();

        // Kick inside a pulse.
        pulse_kick();
        expect_rise(T, "R10 timeout");
        step();
        chk(pull, 1'b1, "R10 pulse cycle 2");
        kick = 1'b1; step(); kick = 1'b0;
        chk(pull, 1'b1, "R10 kick does not cut pulse");
        for (int i = 4; i <= P; i++) begin
            step();
            chk(pull, 1'b1, "R10 pulse held");
        end
        step();
        chk(pull, 1'b0, "R10 release");
        expect_rise(T, "R10 period from release");
        finish_pulse();

        // Reset role: pin level has no effect on the stop request.
        do_reset(1'b1);
        for (int j = 1; j <= 20; j++) begin
            pin_in = logic'(((j / 2) % 2) == 0);
            step();
            chk(stop, 1'b0, "R9 no stop in reset role");
        end

        // Power-down role: no pulse, stop follows the synchronised pin.
        do_reset(1'b0);
        en = 1'b1;
        begin
            logic prev_v = 1'b1;
            for (int j = 1; j <= 6 * T; j++) begin
                logic v = logic'((((j / 3) + (j / 7)) % 2) == 0);
                pin_in = v;
                kick = logic'((j % 5) == 0);
                step();
                chk(pull, 1'b0, "R7 no pull in power-down role");
                chk(stop, ~prev_v, "R8 stop follows pin");
                prev_v = v;
            end
            kick = 1'b0;
        end
    endtask

    initial begin
        rst_n = 1'b0; strap = 1'b1; en = 1'b0; kick = 1'b0; pin_in = 1'b1;
        fork
            run_all();
            begin
                repeat (MAX_CYC) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule